// File: doc/BRIEF.md
# SPI Flash Command Engine

A register-programmed SPI host that runs one flash command transaction at a time. Software writes the command opcode into its own register, then a count of bytes to transmit after the opcode and a count of bytes to receive, and loads the transmit bytes into a shared byte buffer. Setting the start bit launches the transaction. The engine pulls chip select low, shifts out the opcode followed by the transmit bytes on a single data line in SPI mode 0, then clocks in the requested number of receive bytes. It deposits those bytes into the same buffer, directly after the transmit bytes.

Software learns that the transaction is over from a busy flag. Before it starts a transaction, it can check whether the opcode it wrote is on a list of forbidden opcodes that is fixed at elaboration. A forbidden opcode raises an illegal-access flag, and the engine refuses to run it. The SPI clock is the system clock divided by an even, parameter-set divisor. The buffer depth, the divisor and the forbidden list are all parameters.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select (active low) is high, SCLK is low, the busy flag reads 0 and the illegal-access flag reads 0.
- R2: The opcode register sits at byte address 0x45, the transmit count (opcode not included) at 0x48 and the receive count at 0x4B. The buffer occupies addresses 0x80 to 0x80+DEPTH-1. All of these read back the values written.
- R3: A write to address 0x47 with bit 7 set starts a transaction. From the next cycle until the transaction completes, bit 7 of address 0x4F (bit 31 of the status word at 0x4C) reads 1. A write to 0x47 with bit 7 clear starts nothing.
- R4: While chip select is low, the engine shifts out the opcode and then buffer bytes 0 to tx-1, each byte MSB first. MOSI changes only when SCLK falls (or when chip select falls), and SCLK is low whenever chip select is high.
- R5: Receive byte k is sampled on rising SCLK edges and stored at buffer index tx+k. MOSI carries 0xFF for every receive byte.
- R6: A frame has exactly 8*(1+tx+rx) rising SCLK edges. With a receive count of 0, the frame ends after the transmit phase.
- R7: Writing an opcode that is on the forbidden list sets bit 5 of address 0x02 (bit 21 of the control word at 0x00). While that bit is set, start requests are ignored. Writing an opcode that is not on the list clears the bit.
- R8: A start request is ignored when tx+rx exceeds DEPTH. With the default DEPTH of 71, a sum of exactly 71 runs.
- R9: While busy, start requests are ignored, and so are writes to the opcode, to both counts and to the buffer.
- R10: SCLK stays high for SCLK_DIV/2 system clocks. The first rising edge follows the fall of chip select by SCLK_DIV/2 clocks, and chip select rises SCLK_DIV clocks (one SCLK period) after the last falling SCLK edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from bus_addr) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is a register write that arrives during a running frame: a second start, a new opcode, new counts and a buffer overwrite. These are only visible after the frame ends, as a missing second frame and unchanged read-back values. The bench issues such writes while the status bit still shows busy, then checks that the frame count and the buffer contents are unchanged. Random transmit and receive splits, combined with the boundary totals of 0 and exactly DEPTH, exercise the point where receive bytes land just past the transmit bytes. A flash model drives random MISO data and checks every edge time against the divisor.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LEAD,
      SQ_HIGH,
      SQ_LOW,
      SQ_TAIL
   } seq_state_t;

   localparam logic [7:0] ADR_CTRL_B2  = 8'h02;
   localparam logic [7:0] ADR_OPCODE   = 8'h45;
   localparam logic [7:0] ADR_GO       = 8'h47;
   localparam logic [7:0] ADR_TX_CNT   = 8'h48;
   localparam logic [7:0] ADR_RX_CNT   = 8'h4B;
   localparam logic [7:0] ADR_STAT_B3  = 8'h4F;

   localparam int ILLEGAL_BIT = 5;
   localparam int GO_BIT      = 7;
   localparam int BUSY_BIT    = 7;

endpackage

// File: rtl/spi_cmd_opfilter.sv
module spi_cmd_opfilter #(
   parameter int          NUM_BLOCK = 2,
   parameter logic [NUM_BLOCK*8-1:0] BLOCK_OPS = {8'hC7, 8'h60}
) (
   input  logic [7:0] op,
   output logic       hit
);

   generate
      if (NUM_BLOCK == 0) begin : g_none
         assign hit = 1'b0;
      end else begin : g_list
         logic [NUM_BLOCK-1:0] match;
         for (genvar i = 0; i < NUM_BLOCK; i++) begin : g_cmp
            assign match[i] = (op == BLOCK_OPS[i*8 +: 8]);
         end
         assign hit = |match;
      end
   endgenerate

endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
   parameter int SCLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int HALF = SCLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_div
         $error("SCLK_DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // the divider must restart from zero whenever the engine stops
   p_div_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> (cnt == '0));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH = 71,
   parameter int IDXW  = $clog2(DEPTH),
   parameter int BW    = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            tick,
   input  logic [7:0]      opcode,
   input  logic [7:0]      tx_cnt,
   input  logic [7:0]      rx_cnt,
   input  logic [7:0]      rd_data,
   input  logic            miso,
   output logic [BW-1:0]   rd_idx,
   output logic            wr_en,
   output logic [IDXW-1:0] wr_idx,
   output logic [7:0]      wr_data,
   output logic            busy,
   output logic            cs_n,
   output logic            sclk,
   output logic            mosi
);

   seq_state_t      state;
   logic [BW-1:0]   byte_idx;
   logic [2:0]      bit_idx;
   logic [7:0]      tx_sh;
   logic [7:0]      rx_sh;
   logic            tail_half;
   logic [8:0]      last_byte;
   logic            at_last;
   logic            next_is_tx;
   logic            in_rx;
   logic            byte_end;

   assign last_byte  = 9'(tx_cnt) + 9'(rx_cnt);
   assign at_last    = (9'(byte_idx) == last_byte);
   assign next_is_tx = (9'(byte_idx) + 9'd1) <= 9'(tx_cnt);
   assign in_rx      = 9'(byte_idx) > 9'(tx_cnt);
   assign byte_end   = (state == SQ_HIGH) && tick && (bit_idx == 3'd7);

   assign busy    = (state != SQ_IDLE);
   assign mosi    = tx_sh[7];
   assign rd_idx  = byte_idx;
   assign wr_en   = byte_end && in_rx;
   assign wr_idx  = IDXW'(byte_idx - 1'b1);
   assign wr_data = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         cs_n      <= 1'b1;
         sclk      <= 1'b0;
         tx_sh     <= '0;
         rx_sh     <= '0;
         byte_idx  <= '0;
         bit_idx   <= '0;
         tail_half <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (go) begin
                  state    <= SQ_LEAD;
                  cs_n     <= 1'b0;
                  tx_sh    <= opcode;
                  byte_idx <= '0;
                  bit_idx  <= '0;
               end
            end
            SQ_LEAD, SQ_LOW: begin
               if (tick) begin
                  sclk  <= 1'b1;
                  rx_sh <= {rx_sh[6:0], miso};
                  state <= SQ_HIGH;
               end
            end
            SQ_HIGH: begin
               if (tick) begin
                  sclk <= 1'b0;
                  if (bit_idx == 3'd7) begin
                     if (at_last) begin
                        state     <= SQ_TAIL;
                        tail_half <= 1'b0;
                     end else begin
                        byte_idx <= byte_idx + 1'b1;
                        bit_idx  <= '0;
                        tx_sh    <= next_is_tx ? rd_data : 8'hFF;
                        state    <= SQ_LOW;
                     end
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     tx_sh   <= {tx_sh[6:0], 1'b0};
                     state   <= SQ_LOW;
                  end
               end
            end
            SQ_TAIL: begin
               if (tick) begin
                  if (tail_half) begin
                     cs_n  <= 1'b1;
                     state <= SQ_IDLE;
                  end else begin
                     tail_half <= 1'b1;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   p_sclk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   p_mosi_mode0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$past(cs_n) && !$fell(sclk)) |-> $stable(mosi));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < DEPTH));

   p_rx_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (9'(wr_idx) >= 9'(tx_cnt)));

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH     = 71,
   parameter int NUM_BLOCK = 2,
   parameter logic [NUM_BLOCK*8-1:0] BLOCK_OPS = {8'hC7, 8'h60},
   parameter int IDXW      = $clog2(DEPTH),
   parameter int BW        = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_we,
   input  logic [7:0]      bus_addr,
   input  logic [7:0]      bus_wdata,
   output logic [7:0]      bus_rdata,
   input  logic            busy,
   input  logic            eng_we,
   input  logic [IDXW-1:0] eng_idx,
   input  logic [7:0]      eng_data,
   input  logic [BW-1:0]   eng_rd_idx,
   output logic [7:0]      eng_rd_data,
   output logic [7:0]      opcode,
   output logic [7:0]      tx_cnt,
   output logic [7:0]      rx_cnt,
   output logic            go
);

   generate
      if (DEPTH < 1 || DEPTH > 128) begin : g_bad_depth
         $error("DEPTH must lie in 1..128 to fit the buffer window");
      end
   endgenerate

   logic [7:0] buf_q [DEPTH];
   logic       illegal;
   logic       op_hit;
   logic       in_buf;
   logic [6:0] buf_off;
   logic       fits;
   logic       go_req;

   spi_cmd_opfilter #(
      .NUM_BLOCK (NUM_BLOCK),
      .BLOCK_OPS (BLOCK_OPS)
   ) u_filter (
      .op  (bus_wdata),
      .hit (op_hit)
   );

   assign buf_off = bus_addr[6:0];
   assign in_buf  = bus_addr[7] && (int'(buf_off) < DEPTH);
   assign fits    = (9'(tx_cnt) + 9'(rx_cnt)) <= 9'(DEPTH);
   assign go_req  = bus_we && (bus_addr == ADR_GO) && bus_wdata[GO_BIT];
   assign go      = go_req && !busy && !illegal && fits;

   assign eng_rd_data = (int'(eng_rd_idx) < DEPTH) ? buf_q[IDXW'(eng_rd_idx)] : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode  <= '0;
         tx_cnt  <= '0;
         rx_cnt  <= '0;
         illegal <= 1'b0;
      end else if (bus_we && !busy) begin
         unique case (bus_addr)
            ADR_OPCODE: begin
               opcode  <= bus_wdata;
               illegal <= op_hit;
            end
            ADR_TX_CNT: tx_cnt <= bus_wdata;
            ADR_RX_CNT: rx_cnt <= bus_wdata;
            default: ;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_buf
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               buf_q[i] <= '0;
            end else if (eng_we && (int'(eng_idx) == i)) begin
               buf_q[i] <= eng_data;
            end else if (bus_we && !busy && in_buf && (int'(buf_off) == i)) begin
               buf_q[i] <= bus_wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = 8'h00;
      if (in_buf) begin
         bus_rdata = buf_q[IDXW'(buf_off)];
      end else begin
         unique case (bus_addr)
            ADR_CTRL_B2: bus_rdata[ILLEGAL_BIT] = illegal;
            ADR_OPCODE:  bus_rdata = opcode;
            ADR_TX_CNT:  bus_rdata = tx_cnt;
            ADR_RX_CNT:  bus_rdata = rx_cnt;
            ADR_STAT_B3: bus_rdata[BUSY_BIT] = busy;
            default: ;
         endcase
      end
   end

   p_refuse_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && !busy && illegal) |=> !busy);

   p_refuse_oversize_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && !busy && !fits) |=> !busy);

   p_frozen_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(opcode) && $stable(tx_cnt) && $stable(rx_cnt)));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
   parameter int DEPTH     = 71,
   parameter int SCLK_DIV  = 4,
   parameter int NUM_BLOCK = 2,
   parameter logic [NUM_BLOCK*8-1:0] BLOCK_OPS = {8'hC7, 8'h60}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_we,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       spi_cs_n,
   output logic       spi_sclk,
   output logic       spi_mosi,
   input  logic       spi_miso
);

   localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int BW   = $clog2(DEPTH + 1);

   logic            busy;
   logic            go;
   logic            tick;
   logic [7:0]      opcode;
   logic [7:0]      tx_cnt;
   logic [7:0]      rx_cnt;
   logic [BW-1:0]   rd_idx;
   logic [7:0]      rd_data;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [7:0]      wr_data;

   spi_cmd_regs #(
      .DEPTH     (DEPTH),
      .NUM_BLOCK (NUM_BLOCK),
      .BLOCK_OPS (BLOCK_OPS),
      .IDXW      (IDXW),
      .BW        (BW)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .busy        (busy),
      .eng_we      (wr_en),
      .eng_idx     (wr_idx),
      .eng_data    (wr_data),
      .eng_rd_idx  (rd_idx),
      .eng_rd_data (rd_data),
      .opcode      (opcode),
      .tx_cnt      (tx_cnt),
      .rx_cnt      (rx_cnt),
      .go          (go)
   );

   spi_cmd_clkdiv #(
      .SCLK_DIV (SCLK_DIV)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   spi_cmd_seq #(
      .DEPTH (DEPTH),
      .IDXW  (IDXW),
      .BW    (BW)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .tick    (tick),
      .opcode  (opcode),
      .tx_cnt  (tx_cnt),
      .rx_cnt  (rx_cnt),
      .rd_data (rd_data),
      .miso    (spi_miso),
      .rd_idx  (rd_idx),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .busy    (busy),
      .cs_n    (spi_cs_n),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi)
   );

endmodule

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;

   localparam int DEPTH    = 71;
   localparam int SCLK_DIV = 4;
   localparam int HALF     = SCLK_DIV / 2;
   localparam int TCLK     = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       spi_cs_n, spi_sclk, spi_mosi;
   logic       miso_r = 1'b0;

   always #(TCLK/2) clk = ~clk;

   spi_cmd_engine #(.DEPTH(DEPTH), .SCLK_DIV(SCLK_DIV)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .spi_cs_n  (spi_cs_n),
      .spi_sclk  (spi_sclk),
      .spi_mosi  (spi_mosi),
      .spi_miso  (miso_r)
   );

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   // flash model state
   logic [7:0] slv [DEPTH+1];
   logic [7:0] cap [DEPTH+1];
   int   nbit = 0;
   int   frames = 0;
   int   last_bits = 0;
   int   tim_err = 0;
   bit   in_frame = 1'b0;
   time  cs_fall_t, rise_t, fall_t;

   always @(negedge spi_cs_n) begin
      in_frame = 1'b1;
      nbit = 0;
      cs_fall_t = $time;
      for (int i = 0; i <= DEPTH; i++) cap[i] = 8'h00;
      miso_r = slv[0][7];
   end

   always @(posedge spi_sclk) begin
      if (in_frame) begin
         if (nbit == 0 && ($time - cs_fall_t) != HALF*TCLK) tim_err++;
         rise_t = $time;
         if (nbit < 8*(DEPTH+1)) cap[nbit/8] = {cap[nbit/8][6:0], spi_mosi};
         nbit++;
      end
   end

   always @(negedge spi_sclk) begin
      if (in_frame) begin
         if (($time - rise_t) != HALF*TCLK) tim_err++;
         fall_t = $time;
         if (nbit < 8*(DEPTH+1)) miso_r = slv[nbit/8][7 - (nbit%8)];
      end
   end

   always @(posedge spi_cs_n) begin
      if (in_frame) begin
         if (($time - fall_t) != SCLK_DIV*TCLK) tim_err++;
         in_frame = 1'b0;
         last_bits = nbit;
         frames++;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int i = 0; i < 20000; i++) begin
         rd(8'h4F, s);
         if (!s[7]) break;
      end
   endtask

   function automatic bit blocked(input logic [7:0] op);
      return (op == 8'hC7) || (op == 8'h60);
   endfunction

   // full transaction with reference checks
   task automatic run_txn(input logic [7:0] op, input int tx, input int rx, input string tag);
      logic [7:0] txb [DEPTH];
      logic [7:0] v;
      int f0, t0;
      for (int i = 0; i <= DEPTH; i++) slv[i] = 8'($urandom);
      wr(8'h45, op);
      wr(8'h48, 8'(tx));
      wr(8'h4B, 8'(rx));
      for (int i = 0; i < tx; i++) begin
         txb[i] = 8'($urandom);
         wr(8'h80 + 8'(i), txb[i]);
      end
      f0 = frames; t0 = tim_err;
      wr(8'h47, 8'h80);
      rd(8'h4F, v);
      check("R3", {tag, " busy after start"}, int'(v), 8'h80);
      wait_idle();
      repeat (2) @(negedge clk);
      check("R3", {tag, " busy cleared"}, int'(bus_rdata), 0);
      check("R6", {tag, " frame count"}, frames - f0, 1);
      check("R6", {tag, " rising edges"}, last_bits, 8*(1+tx+rx));
      check("R10", {tag, " edge timing"}, tim_err - t0, 0);
      check("R4", {tag, " opcode on MOSI"}, int'(cap[0]), int'(op));
      for (int i = 0; i < tx; i++)
         check("R4", {tag, " tx byte on MOSI"}, int'(cap[1+i]), int'(txb[i]));
      for (int k = 0; k < rx; k++) begin
         check("R5", {tag, " MOSI idle during rx"}, int'(cap[1+tx+k]), 8'hFF);
         rd(8'h80 + 8'(tx+k), v);
         check("R5", {tag, " rx byte placement"}, int'(v), int'(slv[1+tx+k]));
      end
      for (int i = 0; i < tx; i++) begin
         rd(8'h80 + 8'(i), v);
         check("R5", {tag, " tx bytes kept"}, int'(v), int'(txb[i]));
      end
   endtask

   task automatic expect_refused(input string req, input string tag);
      logic [7:0] v;
      int f0 = frames;
      wr(8'h47, 8'h80);
      rd(8'h4F, v);
      check(req, {tag, " busy stays low"}, int'(v), 0);
      repeat (4*SCLK_DIV) @(negedge clk);
      check(req, {tag, " no frame"}, frames - f0, 0);
      check(req, {tag, " cs stays high"}, int'(spi_cs_n), 1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      logic [7:0] op;
      int tx, rx, s;
      s = $urandom(32'd1234);
      for (int i = 0; i <= DEPTH; i++) slv[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "cs_n in reset", int'(spi_cs_n), 1);
      check("R1", "sclk in reset", int'(spi_sclk), 0);
      rst_n = 1'b1;
      rd(8'h4F, v); check("R1", "busy after reset", int'(v), 0);
      rd(8'h02, v); check("R1", "illegal after reset", int'(v), 0);

      // R2 register read-back
      wr(8'h45, 8'h0B); rd(8'h45, v); check("R2", "opcode readback", int'(v), 8'h0B);
      wr(8'h48, 8'd4);  rd(8'h48, v); check("R2", "tx count readback", int'(v), 4);
      wr(8'h4B, 8'd5);  rd(8'h4B, v); check("R2", "rx count readback", int'(v), 5);
      wr(8'h80, 8'hA5); rd(8'h80, v); check("R2", "buffer first", int'(v), 8'hA5);
      wr(8'h80 + 8'(DEPTH-1), 8'h3C); rd(8'h80 + 8'(DEPTH-1), v);
      check("R2", "buffer last", int'(v), 8'h3C);

      // R3 start bit clear does nothing
      wr(8'h47, 8'h7F); rd(8'h4F, v); check("R3", "start bit clear ignored", int'(v), 0);

      // directed corners
      run_txn(8'h06, 0, 0, "R6 opcode only");
      run_txn(8'h02, 3, 0, "R6 no receive");
      run_txn(8'h9F, 0, 3, "R5 read id");
      run_txn(8'h03, 4, DEPTH-4, "R8 full buffer");
      run_txn(8'h02, DEPTH, 0, "R4 tx only full");
      run_txn(8'h0B, 0, DEPTH, "R5 rx only full");

      // R8 oversize refusal
      wr(8'h48, 8'd40); wr(8'h4B, 8'd32);
      expect_refused("R8", "sum 72");

      // R7 blocked opcode
      wr(8'h48, 8'd0); wr(8'h4B, 8'd1);
      wr(8'h45, 8'hC7); rd(8'h02, v); check("R7", "flag set by C7", int'(v), 8'h20);
      expect_refused("R7", "blocked C7");
      wr(8'h45, 8'h60); rd(8'h02, v); check("R7", "flag set by 60", int'(v), 8'h20);
      wr(8'h45, 8'h05); rd(8'h02, v); check("R7", "flag cleared", int'(v), 0);
      run_txn(8'h05, 0, 1, "R7 allowed after clear");

      // R9 writes during busy
      begin
         int f0;
         for (int i = 0; i <= DEPTH; i++) slv[i] = 8'($urandom);
         wr(8'h45, 8'h03); wr(8'h48, 8'd2); wr(8'h4B, 8'd6);
         wr(8'h80, 8'h11); wr(8'h81, 8'h22);
         f0 = frames;
         wr(8'h47, 8'h80);
         wr(8'h47, 8'h80);
         wr(8'h45, 8'h9F);
         wr(8'h48, 8'd9);
         wr(8'h4B, 8'd1);
         wr(8'h80, 8'hEE);
         rd(8'h4F, v); check("R9", "still busy during writes", int'(v), 8'h80);
         wait_idle();
         repeat (4*SCLK_DIV) @(negedge clk);
         check("R9", "one frame only", frames - f0, 1);
         rd(8'h45, v); check("R9", "opcode frozen", int'(v), 8'h03);
         rd(8'h48, v); check("R9", "tx count frozen", int'(v), 2);
         rd(8'h4B, v); check("R9", "rx count frozen", int'(v), 6);
         rd(8'h80, v); check("R9", "buffer frozen", int'(v), 8'h11);
         rd(8'h80 + 8'd2, v); check("R9", "rx after tx", int'(v), int'(slv[3]));
      end

      // random splits
      for (int n = 0; n < 24; n++) begin
         do op = 8'($urandom); while (blocked(op));
         tx = $urandom_range(0, DEPTH);
         rx = $urandom_range(0, DEPTH - tx);
         run_txn(op, tx, rx, "R4 random");
      end

      finish_run();
   end

endmodule